// File: doc/BRIEF.md
# Six-Pin General-Purpose Port with Pin-Change Wake

This block is the parallel I/O port of a small microcontroller core. It holds a six-bit output latch and a six-bit direction register. The direction register cannot be read back and is loaded from the core's working register. A port read returns the synchronized levels seen on the pins, not the latch contents. The read is eight bits wide, and its two top bits are always zero.

Pin 3 can only be an input. Pins given to an alternate function read as zero, and so does pin 3 while it serves as the external reset input. A global option pair controls two features for pins 0, 1 and 3. Both controls are active low and both come up disabled. The first enables weak pull-ups on those pins. The second arms a comparator that raises a wake request when any of those pins differs from the level captured at the last port read. A sticky status flag records that a wake came from a pin change.

Two reset sources act on the block. The asynchronous power-on reset clears all state. The synchronous `soft_rst` (external-reset pin, watchdog or wake) returns the direction register and the option pair to their reset values. It leaves the output latch untouched.

Top module: `gpio_wake_port`

## Requirements
- R1: `rd_data[7:6]` is always 0.
- R2: `rd_data[5:0]` shows the level on `pin_in` two clock edges earlier, whatever the output latch holds. For example, a driven 1 held low from outside reads 0.
- R3: A pin with its `alt_sel` bit set reads 0. Pin 3 also reads 0 while `mclr_mode` is 1.
- R4: `dir_we` loads `w_data[5:0]` into the direction register. A direction bit of 0 sets that pin's `pin_oe`, and a bit of 1 clears it. Power-on reset and `soft_rst` set every direction bit to 1, and `soft_rst` takes priority over `dir_we`.
- R5: `pin_oe[3]` is never 1.
- R6: `data_we` loads `w_data[5:0]` into the latch that drives `pin_out`. The latch holds its value until the next write. `soft_rst` leaves it unchanged, and power-on reset clears it to 0.
- R7: `opt_we` loads `w_data[7:6]` into the option pair; bit 6 is the pull-up control and bit 7 is the wake control, both active low. Power-on reset and `soft_rst` set both bits to 1. `pin_pu[0]`, `pin_pu[1]` and `pin_pu[3]` equal the inverse of bit 6. `pin_pu[3]` is forced to 1 while `mclr_mode` is 1. `pin_pu[2]`, `pin_pu[4]` and `pin_pu[5]` are always 0.
- R8: `rd_en` captures the current synchronized levels of pins 0, 1 and 3 as the wake reference. `wake_req` is 1 when the wake control is 0 and any of those pins differs from the reference. Pin 3 is excluded while `mclr_mode` is 1.
- R9: `wake_flag` is 0 after power-on reset and becomes 1 on the edge after `wake_req` is 1. `soft_rst` clears it unless `wake_req` is 1 in the same cycle. In all other cycles it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous external-pin, watchdog or wake reset |
| w_data | input | 8 | Working-register value for the write strobes |
| data_we | input | 1 | Write strobe for the output latch |
| dir_we | input | 1 | Write strobe for the direction register |
| opt_we | input | 1 | Write strobe for the option pair (bits 7:6) |
| rd_en | input | 1 | Port read strobe; captures the wake reference |
| rd_data | output | 8 | Port read value |
| alt_sel | input | 6 | Static alternate-function assignment per pin |
| mclr_mode | input | 1 | Static: pin 3 serves as the external reset input |
| pin_in | input | 6 | Asynchronous pad input levels |
| pin_out | output | 6 | Pad output data |
| pin_oe | output | 6 | Pad output enable |
| pin_pu | output | 6 | Pad weak pull-up enable |
| wake_req | output | 1 | Pin-change wake request |
| wake_flag | output | 1 | Sticky pin-change wake status |

## Verification
The assertions assume that `alt_sel` and `mclr_mode` are quasi-static configuration, so a pull-up or read mask may change on any cycle in which the configuration changes. They also assume `soft_rst` is synchronous to `clk`. `pin_in` and the strobes may take any value on any cycle. The stimulus changes the configuration inputs only rarely and only at the falling edge. It randomizes pins and strobes every cycle, and it keeps resets sparse so that the latch, the direction register and the wake reference live long enough to be observed.

// File: rtl/gpio_wake_port.sv
`timescale 1ns/1ps
module gpio_wake_port #(
  parameter int PINS    = 6,
  parameter int IN_ONLY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [7:0]      w_data,
  input  logic            data_we,
  input  logic            dir_we,
  input  logic            opt_we,
  input  logic            rd_en,
  output logic [7:0]      rd_data,
  input  logic [PINS-1:0] alt_sel,
  input  logic            mclr_mode,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_pu,
  output logic            wake_req,
  output logic            wake_flag
);
  localparam logic [PINS-1:0] SPECIAL  = PINS'(6'b001011);
  localparam logic [PINS-1:0] IN_MASK  = PINS'(1) << IN_ONLY;
  localparam logic [PINS-1:0] OUT_OK   = ~IN_MASK;

  logic [PINS-1:0] sync1, sync2, dir, lat, snap;
  logic [1:0]      opt_n;
  logic [PINS-1:0] mclr_bit, read_mask, wake_mask;

  assign mclr_bit  = mclr_mode ? IN_MASK : '0;
  assign read_mask = ~alt_sel & ~mclr_bit;
  assign wake_mask = SPECIAL & ~mclr_bit;

  assign rd_data   = {{(8-PINS){1'b0}}, sync2 & read_mask};
  assign pin_out   = lat;
  assign pin_oe    = ~dir & OUT_OK;
  assign pin_pu    = (opt_n[0] ? '0 : SPECIAL) | mclr_bit;
  assign wake_req  = !opt_n[1] && |((sync2 ^ snap) & wake_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      dir       <= '1;
      lat       <= '0;
      opt_n     <= 2'b11;
      snap      <= '0;
      wake_flag <= 1'b0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (soft_rst)    dir <= '1;
      else if (dir_we) dir <= w_data[PINS-1:0];
      if (data_we) lat <= w_data[PINS-1:0];
      if (soft_rst)    opt_n <= 2'b11;
      else if (opt_we) opt_n <= w_data[7:6];
      if (rd_en) snap <= sync2 & SPECIAL;
      if (wake_req)      wake_flag <= 1'b1;
      else if (soft_rst) wake_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_wake_port_chk.sv
`timescale 1ns/1ps
module gpio_wake_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       data_we,
  input logic       mclr_mode,
  input logic [7:0] rd_data,
  input logic [5:0] pin_out,
  input logic [5:0] pin_oe,
  input logic [5:0] pin_pu,
  input logic       wake_req,
  input logic       wake_flag
);
  a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00);
  a_r5_pin3_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[3]);
  a_r4_soft_rst_releases: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> pin_oe == 6'b0);
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we |=> $stable(pin_out));
  a_r7_mclr_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_mode |-> pin_pu[3]);
  a_r7_no_pullup_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pu[2] == 1'b0 && pin_pu[4] == 1'b0 && pin_pu[5] == 1'b0);
  a_r3_mclr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_mode |-> !rd_data[3]);
  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> wake_flag);
  a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !wake_req) |=> !wake_flag);
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !wake_req) |=> $stable(wake_flag));
endmodule

bind gpio_wake_port gpio_wake_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .data_we(data_we),
  .mclr_mode(mclr_mode), .rd_data(rd_data), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_pu(pin_pu), .wake_req(wake_req), .wake_flag(wake_flag)
);

// File: tb/sim_gpio_wake_port.sv
`timescale 1ns/1ps
module sim_gpio_wake_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, data_we = 1'b0, dir_we = 1'b0, opt_we = 1'b0, rd_en = 1'b0;
  logic [7:0] w_data = '0;
  logic [5:0] alt_sel = '0, pin_in = '0;
  logic mclr_mode = 1'b0;
  logic [7:0] rd_data;
  logic [5:0] pin_out, pin_oe, pin_pu;
  logic wake_req, wake_flag;

  always #2 clk = ~clk;

  gpio_wake_port u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .w_data(w_data),
    .data_we(data_we), .dir_we(dir_we), .opt_we(opt_we), .rd_en(rd_en),
    .rd_data(rd_data), .alt_sel(alt_sel), .mclr_mode(mclr_mode),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .wake_req(wake_req), .wake_flag(wake_flag)
  );

  int checks = 0, fails = 0;
  logic [5:0] m_s1 = '0, m_s2 = '0, m_dir = '1, m_lat = '0, m_snap = '0;
  logic [1:0] m_opt = 2'b11;
  logic m_flag = 1'b0;

  function automatic logic [7:0] exp_rd();
    logic [5:0] m = ~alt_sel;
    if (mclr_mode) m[3] = 1'b0;
    return {2'b00, m_s2 & m};
  endfunction
  function automatic logic [5:0] exp_oe();
    return ~m_dir & 6'b110111;
  endfunction
  function automatic logic [5:0] exp_pu();
    logic p = ~m_opt[0];
    return {2'b00, p | mclr_mode, 1'b0, p, p};
  endfunction
  function automatic logic exp_wake();
    logic [5:0] m = mclr_mode ? 6'b000011 : 6'b001011;
    return !m_opt[1] && |((m_s2 ^ m_snap) & m);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R1/R2/R3 rd_data", rd_data, exp_rd());
    check("R6 pin_out", {2'b00, pin_out}, {2'b00, m_lat});
    check("R4/R5 pin_oe", {2'b00, pin_oe}, {2'b00, exp_oe()});
    check("R7 pin_pu", {2'b00, pin_pu}, {2'b00, exp_pu()});
    check("R8 wake_req", {7'b0, wake_req}, {7'b0, exp_wake()});
    check("R9 wake_flag", {7'b0, wake_flag}, {7'b0, m_flag});
  endtask

  task automatic cyc();
    logic wk;
    @(posedge clk);
    wk = exp_wake();
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_dir = '1; m_lat = '0; m_snap = '0;
      m_opt = 2'b11; m_flag = 1'b0;
    end else begin
      if (rd_en) m_snap = m_s2 & 6'b001011;
      m_s2 = m_s1; m_s1 = pin_in;
      if (soft_rst) m_dir = '1; else if (dir_we) m_dir = w_data[5:0];
      if (data_we) m_lat = w_data[5:0];
      if (soft_rst) m_opt = 2'b11; else if (opt_we) m_opt = w_data[7:6];
      if (wk) m_flag = 1'b1; else if (soft_rst) m_flag = 1'b0;
    end
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    soft_rst = 0; data_we = 0; dir_we = 0; opt_we = 0; rd_en = 0;
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) cyc();
    // reset state: R4 all inputs, R6 latch 0, R7 pull-ups off, R9 flag clear
    @(negedge clk); rst_n = 1'b1;
    check_all();
    // R2: latch drives 1 while pads held low -> reads 0
    w_data = 8'h3F; data_we = 1; dir_we = 0; cyc(); idle();
    w_data = 8'h00; dir_we = 1; cyc(); idle();
    pin_in = 6'h00; cyc(); cyc(); cyc();
    check("R2 driven-high held-low", rd_data, 8'h00);
    // R5: pin 3 stays undriven with direction all zero
    check("R5 pin3 oe", {7'b0, pin_oe[3]}, 8'h00);
    // R8: arm wake (bit7=0), pull-ups on (bit6=0), take reference, change pin 1
    w_data = 8'h00; opt_we = 1; cyc(); idle();
    rd_en = 1; cyc(); idle();
    pin_in = 6'h02; cyc(); cyc();
    check("R8 wake on pin1", {7'b0, wake_req}, 8'h01);
    cyc();
    check("R9 flag set", {7'b0, wake_flag}, 8'h01);
    // R8: pin 3 excluded in mclr mode; pin 5 change never wakes
    rd_en = 1; cyc(); idle();
    mclr_mode = 1; pin_in = 6'h2A; cyc(); cyc(); cyc();
    check("R8 mclr pin3/pin5 ignored", {7'b0, wake_req}, 8'h00);
    check("R3 mclr pin3 reads 0", {7'b0, rd_data[3]}, 8'h00);
    // R4/R6/R9: soft reset keeps latch, releases pins, clears flag
    soft_rst = 1; cyc(); idle();
    check("R6 latch kept over soft_rst", {2'b00, pin_out}, 8'h3F);
    check("R4 soft_rst pins released", {2'b00, pin_oe}, 8'h00);
    check("R9 flag cleared", {7'b0, wake_flag}, 8'h00);
    mclr_mode = 0;
    for (int i = 0; i < 4000; i++) begin
      pin_in   = 6'($urandom);
      w_data   = 8'($urandom);
      data_we  = ($urandom % 4) == 0;
      dir_we   = ($urandom % 4) == 0;
      opt_we   = ($urandom % 6) == 0;
      rd_en    = ($urandom % 3) == 0;
      soft_rst = ($urandom % 40) == 0;
      if (($urandom % 50) == 0) mclr_mode = ~mclr_mode;
      if (($urandom % 50) == 0) alt_sel = 6'($urandom);
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule